// File: doc/BRIEF.md
# Network Controller Interrupt Status Unit

This block collects the interrupt causes of an Ethernet network controller into one 8-bit status word and drives a level interrupt line toward the host. The receive, transmit, DMA and tally-counter logic each report events as single-cycle pulses. Each pulse sets a sticky status bit, and that bit holds until software clears it by writing a 1 to its position. An 8-bit mask register selects which status bits may raise the interrupt. The host reaches both registers through a small register port with a one-bit register select.

Bit 7 of the status word is not an event bit. It reports whether the controller is held in reset, or whether the receive ring has overflowed. Controller conditions set and clear it, host writes cannot change it, and it never drives the interrupt.

Status bits 0 to 6 have no reset value. Software must write all ones to the status register once after power-up to bring them to a known state.

Top module: `nic_intr_status`

## Requirements
- R1: A pulse on `rx_good` sets status bit 0, a pulse on `tx_good` sets bit 1, and a pulse on `rdma_done` sets bit 6. Each bit reads as 1 from the clock edge that samples the pulse onward.
- R2: Status bit 2 (receive error) is set by any of `rx_crc_err`, `rx_align_err`, `rx_fifo_overrun` or `rx_missed`. Status bit 3 (transmit error) is set by either `tx_excess_coll` or `tx_fifo_underrun`.
- R3: A pulse on `rx_dma_at_boundary` sets status bit 4. Status bit 5 is set by a 0-to-1 transition of any bit of `tally_msb`. A `tally_msb` bit that stays high sets bit 5 only once.
- R4: Bits 0 to 6 are sticky: they keep their value until a status write (`host_wr`=1, `host_sel_mask`=0) has a 1 in their position, which clears them. A 0 in a write bit leaves that bit unchanged.
- R5: When an event and a write-1-clear hit the same status bit in the same cycle, the bit stays set.
- R6: `irq` is 1 exactly while some status bit 0 to 6 is 1 and the mask bit at the same position is 1. It follows a register change in the same cycle that the register updates.
- R7: A mask write (`host_wr`=1, `host_sel_mask`=1) stores `host_wdata[6:0]`. The mask resets to 0. Mask bit 7 is ignored and always reads as 0.
- R8: Status bit 7 is 1 after reset and is set by `enter_reset` or `ring_overflow`. It is cleared by `start_cmd` or `ring_pkt_removed`. If a set and a clear arrive in the same cycle, the set wins.
- R9: Host writes have no effect on status bit 7, and bit 7 never raises `irq`, whatever the mask holds.
- R10: `host_rdata` shows the status word when `host_sel_mask`=0 and the mask word when `host_sel_mask`=1. It is combinational from the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_good | input | 1 | Frame received without error |
| tx_good | input | 1 | Frame transmitted without error |
| rx_crc_err | input | 1 | Receive CRC error |
| rx_align_err | input | 1 | Receive frame alignment error |
| rx_fifo_overrun | input | 1 | Receive FIFO overrun |
| rx_missed | input | 1 | Receive frame missed |
| tx_excess_coll | input | 1 | Transmit aborted on excessive collisions |
| tx_fifo_underrun | input | 1 | Transmit FIFO underrun |
| rx_dma_at_boundary | input | 1 | Local receive DMA reached the boundary pointer |
| rdma_done | input | 1 | Remote DMA transfer completed |
| tally_msb | input | TALLY_CNT | MSB level of each tally counter |
| enter_reset | input | 1 | Controller enters its stopped/reset state |
| start_cmd | input | 1 | Start command issued |
| ring_overflow | input | 1 | Receive ring overflow |
| ring_pkt_removed | input | 1 | One or more frames removed from the ring |
| host_wr | input | 1 | Host register write strobe |
| host_sel_mask | input | 1 | Register select: 0 status, 1 mask |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bound checker checks on every cycle that each event sets its status bit on the next edge, that a set bit survives any cycle without a clearing write, that a write-1-clear with no competing event clears its bit, and that an event wins over a clear in the same cycle. It also checks on every cycle that the mask takes the written value, that an all-zero mask or an all-zero status keeps `irq` low even while bit 7 is set, and that bit 7 follows its set and clear conditions. Some behaviours can only be shown by the bench scenarios:
- the mapping of each error cause onto bits 2 and 3;
- the single set of bit 5 while a tally MSB stays high;
- the read multiplexer;
- the immunity of bit 7 to host writes.

// File: rtl/nic_intr_status.sv
module nic_intr_status #(
  parameter int TALLY_CNT = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_good,
  input  logic                 tx_good,
  input  logic                 rx_crc_err,
  input  logic                 rx_align_err,
  input  logic                 rx_fifo_overrun,
  input  logic                 rx_missed,
  input  logic                 tx_excess_coll,
  input  logic                 tx_fifo_underrun,
  input  logic                 rx_dma_at_boundary,
  input  logic                 rdma_done,
  input  logic [TALLY_CNT-1:0] tally_msb,
  input  logic                 enter_reset,
  input  logic                 start_cmd,
  input  logic                 ring_overflow,
  input  logic                 ring_pkt_removed,
  input  logic                 host_wr,
  input  logic                 host_sel_mask,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           host_rdata,
  output logic                 irq
);

  localparam int EVT_W = 7;

  logic [EVT_W-1:0]     sticky_q;
  logic [EVT_W-1:0]     mask_q;
  logic                 rst_stat_q;
  logic [TALLY_CNT-1:0] tally_q;
  logic [EVT_W-1:0]     evt_set;
  logic [EVT_W-1:0]     w1c;
  logic                 rx_err, tx_err, tally_rise;

  assign rx_err     = rx_crc_err | rx_align_err | rx_fifo_overrun | rx_missed;
  assign tx_err     = tx_excess_coll | tx_fifo_underrun;
  assign tally_rise = |(tally_msb & ~tally_q);

  assign evt_set = {rdma_done, tally_rise, rx_dma_at_boundary,
                    tx_err, rx_err, tx_good, rx_good};

  assign w1c = (host_wr && !host_sel_mask) ? host_wdata[EVT_W-1:0] : '0;

  // Event bits carry no reset; software clears them after power-up.
  always_ff @(posedge clk)
    sticky_q <= (sticky_q & ~w1c) | evt_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= '0;
      rst_stat_q <= 1'b1;
      tally_q    <= '0;
    end else begin
      tally_q <= tally_msb;
      if (host_wr && host_sel_mask)
        mask_q <= host_wdata[EVT_W-1:0];
      if (enter_reset || ring_overflow)
        rst_stat_q <= 1'b1;
      else if (start_cmd || ring_pkt_removed)
        rst_stat_q <= 1'b0;
    end
  end

  assign host_rdata = host_sel_mask ? {1'b0, mask_q} : {rst_stat_q, sticky_q};
  assign irq        = |(sticky_q & mask_q);

endmodule

module nic_intr_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_good,
  input logic       tx_good,
  input logic       rdma_done,
  input logic       enter_reset,
  input logic       start_cmd,
  input logic       ring_overflow,
  input logic       ring_pkt_removed,
  input logic       host_wr,
  input logic       host_sel_mask,
  input logic [7:0] host_wdata,
  input logic       irq,
  input logic [6:0] sticky_q,
  input logic [6:0] mask_q,
  input logic       rst_stat_q
);
  logic st_wr;
  assign st_wr = host_wr && !host_sel_mask;

  assert_rx_good_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_good |=> sticky_q[0]);
  assert_dma_done_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rdma_done |=> sticky_q[6]);
  assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && host_wdata[0] && !rx_good) |=> !sticky_q[0]);
  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && host_wdata[1] && tx_good) |=> sticky_q[1]);
  assert_zero_mask_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel_mask && host_wdata[6:0] == 7'd0) |=> !irq);
  assert_mask_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel_mask) |=> (mask_q == $past(host_wdata[6:0])));
  assert_ovf_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_overflow || enter_reset) |=> rst_stat_q);
  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_cmd || ring_pkt_removed) && !ring_overflow && !enter_reset) |=> !rst_stat_q);
  assert_bit7_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q == 7'd0) |-> !irq);
endmodule

bind nic_intr_status nic_intr_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_good(rx_good), .tx_good(tx_good),
  .rdma_done(rdma_done), .enter_reset(enter_reset), .start_cmd(start_cmd),
  .ring_overflow(ring_overflow), .ring_pkt_removed(ring_pkt_removed),
  .host_wr(host_wr), .host_sel_mask(host_sel_mask), .host_wdata(host_wdata),
  .irq(irq), .sticky_q(sticky_q), .mask_q(mask_q), .rst_stat_q(rst_stat_q)
);

// File: tb/nic_intr_status_tb.sv
`timescale 1ns/1ps
module nic_intr_status_tb;
  localparam int TC = 3;

  logic clk = 0, rst_n = 0;
  logic rx_good = 0, tx_good = 0, rx_crc_err = 0, rx_align_err = 0;
  logic rx_fifo_overrun = 0, rx_missed = 0, tx_excess_coll = 0, tx_fifo_underrun = 0;
  logic rx_dma_at_boundary = 0, rdma_done = 0;
  logic [TC-1:0] tally_msb = '0;
  logic enter_reset = 0, start_cmd = 0, ring_overflow = 0, ring_pkt_removed = 0;
  logic host_wr = 0, host_sel_mask = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nic_intr_status #(.TALLY_CNT(TC)) u_dut (.*);

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic set_evt(input int idx, input logic v);
    case (idx)
      0: rx_good = v;            1: tx_good = v;
      2: rx_crc_err = v;         3: rx_align_err = v;
      4: rx_fifo_overrun = v;    5: rx_missed = v;
      6: tx_excess_coll = v;     7: tx_fifo_underrun = v;
      8: rx_dma_at_boundary = v; 9: rdma_done = v;
      10: enter_reset = v;       11: start_cmd = v;
      12: ring_overflow = v;     13: ring_pkt_removed = v;
      default: ;
    endcase
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); set_evt(idx, 1);
    @(negedge clk); set_evt(idx, 0);
  endtask

  task automatic hwrite(input logic sel, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_sel_mask = sel; host_wdata = d;
    @(negedge clk); host_wr = 0; host_sel_mask = 0;
  endtask

  function automatic logic [7:0] rd(input logic sel);
    host_sel_mask = sel;
    return 8'h00;
  endfunction

  task automatic hread(input logic sel, output logic [7:0] d);
    host_sel_mask = sel; #0.5; d = host_rdata; host_sel_mask = 0; #0.1;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1;
    hread(1'b1, d); check("R7 mask reset", d, 8'h00);
    hread(1'b0, d); check("R8 bit7 after reset", {7'd0, d[7]}, 8'h01);
    hwrite(1'b0, 8'hFF);
    hread(1'b0, d); check("R4 power-up clear", d, 8'h80);
    check("R6 irq idle", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_good_events;
    logic [7:0] d;
    pulse(0); hread(1'b0, d); check("R1 rx_good bit0", d & 8'h7F, 8'h01);
    pulse(1); hread(1'b0, d); check("R1 tx_good bit1", d & 8'h7F, 8'h03);
    pulse(9); hread(1'b0, d); check("R1 rdma_done bit6", d & 8'h7F, 8'h43);
    hwrite(1'b0, 8'h7F);
  endtask

  task automatic t_errors;
    logic [7:0] d;
    for (int i = 2; i <= 5; i++) begin
      pulse(i); hread(1'b0, d); check("R2 rx error cause", d & 8'h7F, 8'h04);
      hwrite(1'b0, 8'h04);
    end
    for (int i = 6; i <= 7; i++) begin
      pulse(i); hread(1'b0, d); check("R2 tx error cause", d & 8'h7F, 8'h08);
      hwrite(1'b0, 8'h08);
    end
  endtask

  task automatic t_ovw_tally;
    logic [7:0] d;
    pulse(8); hread(1'b0, d); check("R3 boundary bit4", d & 8'h7F, 8'h10);
    hwrite(1'b0, 8'h10);
    @(negedge clk); tally_msb = 3'b010;
    repeat (2) @(negedge clk);
    hread(1'b0, d); check("R3 tally rise bit5", d & 8'h7F, 8'h20);
    hwrite(1'b0, 8'h20);
    repeat (3) @(negedge clk);
    hread(1'b0, d); check("R3 held msb no reset", d & 8'h7F, 8'h00);
    tally_msb = 3'b110;
    @(negedge clk); tally_msb = 3'b000;
    hread(1'b0, d); check("R3 second counter rise", d & 8'h7F, 8'h20);
    hwrite(1'b0, 8'h20);
  endtask

  task automatic t_w1c;
    logic [7:0] d;
    pulse(0); pulse(1); pulse(9);
    hwrite(1'b0, 8'h02);
    hread(1'b0, d); check("R4 partial clear", d & 8'h7F, 8'h41);
    hwrite(1'b0, 8'h00);
    hread(1'b0, d); check("R4 zero write keeps", d & 8'h7F, 8'h41);
    hwrite(1'b0, 8'h41);
    hread(1'b0, d); check("R4 full clear", d & 8'h7F, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    pulse(0);
    @(negedge clk); host_wr = 1; host_sel_mask = 0; host_wdata = 8'h01; rx_good = 1;
    @(negedge clk); host_wr = 0; rx_good = 0;
    hread(1'b0, d); check("R5 event beats clear", d & 8'h7F, 8'h01);
    hwrite(1'b0, 8'h01);
    hread(1'b0, d); check("R5 clear afterwards", d & 8'h7F, 8'h00);
  endtask

  task automatic t_irq_mask;
    logic [7:0] d;
    hwrite(1'b1, 8'hFF);
    hread(1'b1, d); check("R7 mask bit7 ignored", d, 8'h7F);
    hwrite(1'b1, 8'h08);
    pulse(1);
    check("R6 masked bit no irq", {7'd0, irq}, 8'h00);
    @(negedge clk); tx_fifo_underrun = 1;
    @(negedge clk); tx_fifo_underrun = 0;
    check("R6 unmasked bit irq", {7'd0, irq}, 8'h01);
    hwrite(1'b0, 8'h02);
    check("R6 irq holds while bit3 set", {7'd0, irq}, 8'h01);
    hwrite(1'b0, 8'h08);
    check("R6 irq drops", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_rst_status;
    logic [7:0] d;
    pulse(11); hread(1'b0, d); check("R8 start clears", {7'd0, d[7]}, 8'h00);
    pulse(12); hread(1'b0, d); check("R8 ring overflow sets", {7'd0, d[7]}, 8'h01);
    pulse(13); hread(1'b0, d); check("R8 removal clears", {7'd0, d[7]}, 8'h00);
    @(negedge clk); enter_reset = 1; start_cmd = 1;
    @(negedge clk); enter_reset = 0; start_cmd = 0;
    hread(1'b0, d); check("R8 set wins", {7'd0, d[7]}, 8'h01);
  endtask

  task automatic t_bit7;
    logic [7:0] d;
    hwrite(1'b0, 8'h80);
    hread(1'b0, d); check("R9 write ignored on bit7", d, 8'h80);
    hwrite(1'b1, 8'hFF);
    check("R9 bit7 no irq", {7'd0, irq}, 8'h00);
    pulse(11);
    hwrite(1'b0, 8'h80);
    hread(1'b0, d); check("R9 write cannot set bit7", d, 8'h00);
    hread(1'b1, d); check("R10 read mask select", d, 8'h7F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_good_events();
    t_errors();
    t_ovw_tally();
    t_w1c();
    t_collide();
    t_irq_mask();
    hwrite(1'b1, 8'h00);
    t_rst_status();
    t_bit7();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule